// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block steps a multicycle 32-bit load/store processor through each instruction. It keeps a 4-bit state register, and in every cycle it drives the datapath control lines: memory strobes, instruction-register load, PC update and PC source, register-file write and its destination and data selects, the ALU operand selects, the ALU operation, and a register-pair select. The control word comes from a 16-entry table indexed by state. The next state comes from a second table indexed by the opcode joined with the current state.

All control outputs are registered. Each register loads the table row of the state being entered, so the outputs always line up with the state register. The R-type function field is resolved into a subtract flag in the same register stage. Besides ALU, load, store, branch and jump instructions, the sequencer runs a store-pair instruction. That instruction writes register rt and register rt+1 to two consecutive words. It uses a constant-1 ALU operand, an immediate+4 operand and a second-read-port select that reads rt+1.

Encodings used below:
- ALU A select (`alu_a_sel_o`): 0 = PC, 1 = register A, 2 = constant 1.
- ALU B select (`alu_b_sel_o`): 0 = register B, 1 = constant 4, 2 = sign-extended immediate, 3 = shifted immediate, 4 = immediate+4.
- `alu_op_o`: 0 = add, 1 = subtract, 2 = use the function field.
- `pc_src_o`: 0 = ALU result, 1 = ALUout, 2 = jump target.
- Unlisted control lines are 0.

Top module: `mcc_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs show the fetch word at once, without waiting for a clock. The fetch word is mem_rd=1, ir_wr=1, pc_wr=1, pc_src=0, addr_sel=0, a_sel=0, b_sel=1, alu_op=0, and all other lines 0, with alu_sub=0. After release, the fetch word is held for two more rising edges.
- R2: Fetch is always followed by decode. The decode word has a_sel=0, b_sel=3, alu_op=0 and all other lines 0.
- R3: Opcode 0 runs two states after decode, then returns to fetch. The first is an execute state (a_sel=1, b_sel=0, alu_op=2), in which alu_sub=1 for function code 34 and alu_sub=0 for code 32 or any other code. The second is a completion state (reg_wr=1, reg_dst=1, mem_to_reg=0).
- R4: Opcode 35 runs three states after decode, then returns to fetch. They are an address state (a_sel=1, b_sel=2, alu_op=0), a read state (mem_rd=1, addr_sel=1) and a write-back state (reg_wr=1, mem_to_reg=1, reg_dst=0).
- R5: Opcode 43 runs two states after decode, then returns to fetch: the address state, then a write state (mem_wr=1, addr_sel=1).
- R6: Opcode 23 runs five states after decode, then returns to fetch. In order they are:
  1. an address state (a_sel=1, b_sel=2);
  2. a write state (mem_wr=1, addr_sel=1);
  3. a pair-read state (pair_sel=1, a_sel=2, b_sel=0);
  4. a second address state (a_sel=1, b_sel=4);
  5. a second write state (mem_wr=1, addr_sel=1).
- R7: Opcode 4 runs one state after decode (a_sel=1, b_sel=0, alu_op=1, alu_sub=1, pc_wr_cond=1, pc_src=1). Opcode 2 runs one state after decode (pc_wr=1, pc_src=2). Both then return to fetch.
- R8: reg_wr is 1 only in the R-type completion and load write-back states. mem_wr is 1 only in the store and store-pair write states. mem_rd and mem_wr are never 1 together.
- R9: Any opcode other than 0, 2, 4, 23, 35 and 43 goes from decode straight back to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| opcode_i | input | 6 | Opcode field of the instruction register |
| funct_i | input | 6 | Function field of the instruction register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| ir_wr_o | output | 1 | Instruction register load |
| pc_wr_o | output | 1 | Unconditional PC load |
| pc_wr_cond_o | output | 1 | PC load when ALU result is zero |
| pc_src_o | output | 2 | PC source select |
| addr_sel_o | output | 1 | Memory address: 0 = PC, 1 = ALUout |
| reg_wr_o | output | 1 | Register file write enable |
| reg_dst_o | output | 1 | Write register: 0 = rt, 1 = rd |
| mem_to_reg_o | output | 1 | Write data: 0 = ALUout, 1 = MDR |
| alu_a_sel_o | output | 2 | ALU A operand select |
| alu_b_sel_o | output | 3 | ALU B operand select |
| alu_op_o | output | 2 | ALU operation class |
| pair_sel_o | output | 1 | Second read port addresses rt+1 |
| alu_sub_o | output | 1 | Resolved ALU subtract |

## Verification
The assertions assume that `opcode_i` and `funct_i` stay stable from the fetch state until the instruction returns to fetch, as they would when taken from a held instruction register. They also assume that `funct_i` is known whenever an R-type execute state is entered. The stimulus changes both fields only while fetch is showing. It picks a fresh opcode from the six defined ones or from the whole 6-bit range, with function codes 32, 34 or any random value. Reset is driven asynchronously, including in the middle of a store-pair sequence.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OP_BITS = 6;
  localparam int ST_BITS = 4;

  localparam logic [OP_BITS-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OP_BITS-1:0] OPC_JMP   = 6'd2;
  localparam logic [OP_BITS-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OP_BITS-1:0] OPC_PAIR  = 6'd23;
  localparam logic [OP_BITS-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OP_BITS-1:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_SUB = 6'd34;

  localparam logic [ST_BITS-1:0] S_FETCH  = 4'd0;
  localparam logic [ST_BITS-1:0] S_DECODE = 4'd1;
  localparam logic [ST_BITS-1:0] S_MADDR  = 4'd2;
  localparam logic [ST_BITS-1:0] S_LRD    = 4'd3;
  localparam logic [ST_BITS-1:0] S_LWB    = 4'd4;
  localparam logic [ST_BITS-1:0] S_SWR    = 4'd5;
  localparam logic [ST_BITS-1:0] S_REXE   = 4'd6;
  localparam logic [ST_BITS-1:0] S_RDONE  = 4'd7;
  localparam logic [ST_BITS-1:0] S_BEQ    = 4'd8;
  localparam logic [ST_BITS-1:0] S_JMP    = 4'd9;
  localparam logic [ST_BITS-1:0] S_PADR1  = 4'd10;
  localparam logic [ST_BITS-1:0] S_PWR1   = 4'd11;
  localparam logic [ST_BITS-1:0] S_PINC   = 4'd12;
  localparam logic [ST_BITS-1:0] S_PADR2  = 4'd13;
  localparam logic [ST_BITS-1:0] S_PWR2   = 4'd14;

  localparam logic [1:0] A_PC = 2'd0, A_REG = 2'd1, A_ONE = 2'd2;
  localparam logic [2:0] B_REG = 3'd0, B_FOUR = 3'd1, B_IMM = 3'd2,
                         B_SHIMM = 3'd3, B_IMM4 = 3'd4;
  localparam logic [1:0] OP_ADD = 2'd0, OP_SUB = 2'd1, OP_FN = 2'd2;
  localparam logic [1:0] PCS_ALU = 2'd0, PCS_OUT = 2'd1, PCS_JMP = 2'd2;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       pc_wr;
    logic       pc_cond;
    logic [1:0] pc_src;
    logic       addr_sel;
    logic       reg_wr;
    logic       reg_dst;
    logic       m2r;
    logic [1:0] a_sel;
    logic [2:0] b_sel;
    logic [1:0] alu_op;
    logic       pair;
  } ctl_t;

  function automatic ctl_t ctl_of(input logic [ST_BITS-1:0] st);
    ctl_t c;
    c = '0;
    case (st)
      S_FETCH: begin
        c.mem_rd = 1'b1; c.ir_wr = 1'b1; c.pc_wr = 1'b1;
        c.a_sel = A_PC; c.b_sel = B_FOUR; c.alu_op = OP_ADD;
      end
      S_DECODE: begin
        c.a_sel = A_PC; c.b_sel = B_SHIMM; c.alu_op = OP_ADD;
      end
      S_MADDR, S_PADR1: begin
        c.a_sel = A_REG; c.b_sel = B_IMM; c.alu_op = OP_ADD;
      end
      S_LRD: begin
        c.mem_rd = 1'b1; c.addr_sel = 1'b1;
      end
      S_LWB: begin
        c.reg_wr = 1'b1; c.m2r = 1'b1;
      end
      S_SWR, S_PWR1, S_PWR2: begin
        c.mem_wr = 1'b1; c.addr_sel = 1'b1;
      end
      S_REXE: begin
        c.a_sel = A_REG; c.b_sel = B_REG; c.alu_op = OP_FN;
      end
      S_RDONE: begin
        c.reg_wr = 1'b1; c.reg_dst = 1'b1;
      end
      S_BEQ: begin
        c.a_sel = A_REG; c.b_sel = B_REG; c.alu_op = OP_SUB;
        c.pc_cond = 1'b1; c.pc_src = PCS_OUT;
      end
      S_JMP: begin
        c.pc_wr = 1'b1; c.pc_src = PCS_JMP;
      end
      S_PINC: begin
        c.pair = 1'b1; c.a_sel = A_ONE; c.b_sel = B_REG;
      end
      S_PADR2: begin
        c.a_sel = A_REG; c.b_sel = B_IMM4; c.alu_op = OP_ADD;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [ST_BITS-1:0] next_of(input logic [OP_BITS-1:0] op,
                                                 input logic [ST_BITS-1:0] st);
    logic [ST_BITS-1:0] n;
    n = S_FETCH;
    case (st)
      S_FETCH:  n = S_DECODE;
      S_DECODE: begin
        case (op)
          OPC_RTYPE:           n = S_REXE;
          OPC_LOAD, OPC_STORE: n = S_MADDR;
          OPC_BEQ:             n = S_BEQ;
          OPC_JMP:             n = S_JMP;
          OPC_PAIR:            n = S_PADR1;
          default:             n = S_FETCH;
        endcase
      end
      S_MADDR:  n = (op == OPC_LOAD)  ? S_LRD :
                    (op == OPC_STORE) ? S_SWR : S_FETCH;
      S_LRD:    n = S_LWB;
      S_REXE:   n = S_RDONE;
      S_PADR1:  n = S_PWR1;
      S_PWR1:   n = S_PINC;
      S_PINC:   n = S_PADR2;
      S_PADR2:  n = S_PWR2;
      default:  n = S_FETCH;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mcc_rst_sync.sv
module mcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mcc_seq_rom.sv
module mcc_seq_rom #(
  parameter int OP_W = mcc_pkg::OP_BITS,
  parameter int ST_W = mcc_pkg::ST_BITS
) (
  input  logic [OP_W-1:0] opcode,
  input  logic [ST_W-1:0] state,
  output logic [ST_W-1:0] next_state
);
  localparam int AW    = OP_W + ST_W;
  localparam int DEPTH = 1 << AW;

  logic [ST_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign rom[g] = mcc_pkg::next_of(OP_W'(g >> ST_W), ST_W'(g));
  end

  assign next_state = rom[{opcode, state}];
endmodule

// File: rtl/mcc_ctl_rom.sv
module mcc_ctl_rom #(
  parameter int ST_W = mcc_pkg::ST_BITS
) (
  input  logic [ST_W-1:0] state,
  output mcc_pkg::ctl_t   word
);
  localparam int DEPTH = 1 << ST_W;

  mcc_pkg::ctl_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign rom[g] = mcc_pkg::ctl_of(ST_W'(g));
  end

  assign word = rom[state];
endmodule

// File: rtl/mcc_alu_dec.sv
module mcc_alu_dec #(
  parameter int FN_W = 6
) (
  input  logic [1:0]      alu_op,
  input  logic [FN_W-1:0] funct,
  output logic            sub
);
  always_comb begin
    case (alu_op)
      mcc_pkg::OP_SUB: sub = 1'b1;
      mcc_pkg::OP_FN:  sub = (funct == FN_W'(mcc_pkg::FN_SUB));
      default:         sub = 1'b0;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl #(
  parameter int OP_W = 6,
  parameter int FN_W = 6,
  parameter int ST_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode_i,
  input  logic [FN_W-1:0] funct_i,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            ir_wr_o,
  output logic            pc_wr_o,
  output logic            pc_wr_cond_o,
  output logic [1:0]      pc_src_o,
  output logic            addr_sel_o,
  output logic            reg_wr_o,
  output logic            reg_dst_o,
  output logic            mem_to_reg_o,
  output logic [1:0]      alu_a_sel_o,
  output logic [2:0]      alu_b_sel_o,
  output logic [1:0]      alu_op_o,
  output logic            pair_sel_o,
  output logic            alu_sub_o
);
  import mcc_pkg::*;

  localparam ctl_t CTL_RST = ctl_of(S_FETCH);

  logic            rst_sync_n;
  logic [ST_W-1:0] state_q, state_d;
  ctl_t            ctl_q, ctl_d;
  logic            sub_q, sub_d;

  mcc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mcc_seq_rom #(.OP_W(OP_W), .ST_W(ST_W)) u_seq (
    .opcode(opcode_i), .state(state_q), .next_state(state_d)
  );

  mcc_ctl_rom #(.ST_W(ST_W)) u_ctl (
    .state(state_d), .word(ctl_d)
  );

  mcc_alu_dec #(.FN_W(FN_W)) u_alu (
    .alu_op(ctl_d.alu_op), .funct(funct_i), .sub(sub_d)
  );

  // Outputs are loaded with the row of the state being entered, so the
  // output register and the state register always agree (Moore timing).
  // The asynchronous path through rst_n forces the fetch word at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      sub_q <= 1'b0;
    end else if (!rst_sync_n) begin
      ctl_q <= CTL_RST;
      sub_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      sub_q <= sub_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           state_q <= S_FETCH;
    else if (!rst_sync_n) state_q <= S_FETCH;
    else                  state_q <= state_d;
  end

  assign mem_rd_o     = ctl_q.mem_rd;
  assign mem_wr_o     = ctl_q.mem_wr;
  assign ir_wr_o      = ctl_q.ir_wr;
  assign pc_wr_o      = ctl_q.pc_wr;
  assign pc_wr_cond_o = ctl_q.pc_cond;
  assign pc_src_o     = ctl_q.pc_src;
  assign addr_sel_o   = ctl_q.addr_sel;
  assign reg_wr_o     = ctl_q.reg_wr;
  assign reg_dst_o    = ctl_q.reg_dst;
  assign mem_to_reg_o = ctl_q.m2r;
  assign alu_a_sel_o  = ctl_q.a_sel;
  assign alu_b_sel_o  = ctl_q.b_sel;
  assign alu_op_o     = ctl_q.alu_op;
  assign pair_sel_o   = ctl_q.pair;
  assign alu_sub_o    = sub_q;

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_FETCH) |=> (state_q == S_DECODE)); // R2

  AST_LOAD_READ_THEN_WB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_LRD) |=> (reg_wr_o && mem_to_reg_o && !reg_dst_o)); // R4

  AST_PAIR_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_PWR1) |=> (pair_sel_o && alu_a_sel_o == A_ONE)); // R6

  AST_BRANCH_SUBTRACTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_BEQ) |-> (alu_sub_o && pc_wr_cond_o)); // R7

  AST_REGWR_ENDS_INSTR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr_o |=> (state_q == S_FETCH)); // R8

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_rd_o && mem_wr_o)); // R8

  AST_UNDEF_OP_RETURNS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == S_DECODE && opcode_i != OPC_RTYPE && opcode_i != OPC_JMP &&
     opcode_i != OPC_BEQ && opcode_i != OPC_PAIR && opcode_i != OPC_LOAD &&
     opcode_i != OPC_STORE) |=> (state_q == S_FETCH)); // R9

endmodule

// File: tb/mcc_ctrl_bench.sv
`timescale 1ns/1ps
module mcc_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] opcode, funct;
  logic mem_rd, mem_wr, ir_wr, pc_wr, pc_cond, addr_sel, reg_wr, reg_dst, m2r, pair, sub;
  logic [1:0] pc_src, a_sel, alu_op;
  logic [2:0] b_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mcc_ctrl u_mcc_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .funct_i(funct),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .ir_wr_o(ir_wr), .pc_wr_o(pc_wr),
    .pc_wr_cond_o(pc_cond), .pc_src_o(pc_src), .addr_sel_o(addr_sel),
    .reg_wr_o(reg_wr), .reg_dst_o(reg_dst), .mem_to_reg_o(m2r),
    .alu_a_sel_o(a_sel), .alu_b_sel_o(b_sel), .alu_op_o(alu_op),
    .pair_sel_o(pair), .alu_sub_o(sub)
  );

  // Bench-side step names (numbering private to the bench).
  localparam int T_FET = 0, T_DEC = 1, T_ADR = 2, T_LRD = 3, T_LWB = 4,
                 T_SWR = 5, T_EXE = 6, T_RDN = 7, T_BEQ = 8, T_JMP = 9,
                 T_PA1 = 10, T_PW1 = 11, T_PRD = 12, T_PA2 = 13, T_PW2 = 14;

  function automatic bit known_op(logic [5:0] op);
    return op == 6'd0 || op == 6'd2 || op == 6'd4 || op == 6'd23 ||
           op == 6'd35 || op == 6'd43;
  endfunction

  function automatic int step_after(logic [5:0] op, int t);
    case (t)
      T_FET: return T_DEC;
      T_DEC: begin
        if (op == 6'd0)                   return T_EXE;
        if (op == 6'd35 || op == 6'd43)   return T_ADR;
        if (op == 6'd4)                   return T_BEQ;
        if (op == 6'd2)                   return T_JMP;
        if (op == 6'd23)                  return T_PA1;
        return T_FET;
      end
      T_ADR: return (op == 6'd35) ? T_LRD : T_SWR;
      T_LRD: return T_LWB;
      T_EXE: return T_RDN;
      T_PA1: return T_PW1;
      T_PW1: return T_PRD;
      T_PRD: return T_PA2;
      T_PA2: return T_PW2;
      default: return T_FET;
    endcase
  endfunction

  function automatic logic [19:0] expect_vec(int t, logic [5:0] fn);
    logic rd, wr, ir, pw, pc, as, rw, rdst, mr, pr, sb;
    logic [1:0] ps, a, op;
    logic [2:0] b;
    {rd, wr, ir, pw, pc, as, rw, rdst, mr, pr, sb} = '0;
    ps = 2'd0; a = 2'd0; op = 2'd0; b = 3'd0;
    case (t)
      T_FET: begin rd = 1; ir = 1; pw = 1; b = 3'd1; end
      T_DEC: b = 3'd3;
      T_ADR, T_PA1: begin a = 2'd1; b = 3'd2; end
      T_LRD: begin rd = 1; as = 1; end
      T_LWB: begin rw = 1; mr = 1; end
      T_SWR, T_PW1, T_PW2: begin wr = 1; as = 1; end
      T_EXE: begin a = 2'd1; op = 2'd2; sb = (fn == 6'd34); end
      T_RDN: begin rw = 1; rdst = 1; end
      T_BEQ: begin a = 2'd1; op = 2'd1; sb = 1; pc = 1; ps = 2'd1; end
      T_JMP: begin pw = 1; ps = 2'd2; end
      T_PRD: begin pr = 1; a = 2'd2; end
      T_PA2: begin a = 2'd1; b = 3'd4; end
      default: ;
    endcase
    return {rd, wr, ir, pw, pc, ps, as, rw, rdst, mr, a, b, op, pr, sb};
  endfunction

  function automatic string tag_of(int t, logic [5:0] op);
    case (t)
      T_FET, T_DEC: return "R2";
      T_EXE, T_RDN: return "R3";
      T_LRD, T_LWB: return "R4";
      T_SWR:        return "R5";
      T_PA1, T_PW1, T_PRD, T_PA2, T_PW2: return "R6";
      T_BEQ, T_JMP: return "R7";
      T_ADR:        return (op == 6'd23) ? "R6" : (op == 6'd35) ? "R4" : "R5";
      default:      return "R2";
    endcase
  endfunction

  function automatic logic [19:0] got_vec();
    return {mem_rd, mem_wr, ir_wr, pc_wr, pc_cond, pc_src, addr_sel, reg_wr,
            reg_dst, m2r, a_sel, b_sel, alu_op, pair, sub};
  endfunction

  task automatic check_vec(string tag, int t, logic [5:0] fn);
    logic [19:0] e, g;
    e = expect_vec(t, fn);
    g = got_vec();
    n_chk++;
    if (g !== e) begin
      n_err++;
      $display("FAIL %s step %0d got %h expected %h", tag, t, g, e);
    end
  endtask

  // R8: write strobes only in their own steps; never read with write.
  task automatic check_r8(int t);
    logic e_rw, e_mw;
    e_rw = (t == T_RDN || t == T_LWB);
    e_mw = (t == T_SWR || t == T_PW1 || t == T_PW2);
    n_chk++;
    if (reg_wr !== e_rw || mem_wr !== e_mw || (mem_rd && mem_wr)) begin
      n_err++;
      $display("FAIL R8 step %0d got rw=%b mw=%b mr=%b expected rw=%b mw=%b mr&mw=0",
               t, reg_wr, mem_wr, mem_rd, e_rw, e_mw);
    end
  endtask

  // Called at a negedge with the fetch step showing; ends at the next fetch.
  task automatic run_instr(logic [5:0] op, logic [5:0] fn);
    int t;
    string tg;
    opcode = op;
    funct = fn;
    t = T_FET;
    do begin
      tg = tag_of(t, op);
      if (t == T_DEC && !known_op(op)) tg = "R9";
      check_vec(tg, t, fn);
      check_r8(t);
      @(posedge clk);
      @(negedge clk);
      t = step_after(op, t);
    end while (t != T_FET);
    check_vec(known_op(op) ? tag_of(T_FET, op) : "R9", T_FET, fn);
  endtask

  task automatic reset_and_release();
    #1 rst_n = 1'b0;
    #0.5 check_vec("R1", T_FET, funct);
    @(posedge clk); @(negedge clk);
    check_vec("R1", T_FET, funct);
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_vec("R1", T_FET, funct);
    @(posedge clk); @(negedge clk);
    check_vec("R1", T_FET, funct);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] ops [6];
    ops[0] = 6'd0; ops[1] = 6'd2; ops[2] = 6'd4;
    ops[3] = 6'd23; ops[4] = 6'd35; ops[5] = 6'd43;
    void'($urandom(32'd7151));
    rst_n = 1'b0;
    opcode = 6'd0;
    funct = 6'd0;
    @(negedge clk);
    reset_and_release();

    // Directed: every defined opcode, both R-type codes, odd function code.
    run_instr(6'd0, 6'd32);   // R3 add
    run_instr(6'd0, 6'd34);   // R3 subtract
    run_instr(6'd0, 6'd63);   // R3 other code adds
    run_instr(6'd35, 6'd0);   // R4
    run_instr(6'd43, 6'd0);   // R5
    run_instr(6'd23, 6'd34);  // R6
    run_instr(6'd4, 6'd0);    // R7 branch
    run_instr(6'd2, 6'd0);    // R7 jump
    run_instr(6'd1, 6'd0);    // R9
    run_instr(6'd63, 6'd34);  // R9

    // R1: reset in the middle of a store-pair sequence.
    opcode = 6'd23;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    reset_and_release();
    run_instr(6'd23, 6'd0);

    // Constrained random mix.
    for (int i = 0; i < 300; i++) begin
      logic [5:0] op, fn;
      int pick;
      pick = $urandom_range(0, 8);
      op = (pick < 6) ? ops[pick] : 6'($urandom_range(0, 63));
      pick = $urandom_range(0, 2);
      fn = (pick == 0) ? 6'd32 : (pick == 1) ? 6'd34 : 6'($urandom_range(0, 63));
      run_instr(op, fn);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule